// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block watches the two phase lines of an incremental quadrature encoder and keeps a signed position count of configurable width (32 bits by default). On each sampling tick it forms a 4-bit code from the previous and the new phase pair and looks that code up in a fixed transition table. The result is one count up, one count down, or no change. Both phase lines pass through a two-flop synchroniser before they are sampled. A clock-enable divider sets how often a sample is taken, so the logic can run slower when a low maximum step rate is enough.

After every sample the block writes the current count into a small receive queue and never waits for space. When the queue is full, the snapshot is discarded and counting carries on. The queue therefore tends to hold old values. A reader that needs the present position reads the fill level N, pops N+1 entries and keeps only the last one.

Top module: `qenc_counter`

## Requirements
- R1: The action is chosen by the code {prev[1:0], new[1:0]} with prev in bits 3:2 and bit 1 of each pair the A line. Codes 0010, 0100, 1011 and 1101 add one. Codes 0001, 0111, 1000 and 1110 subtract one. All other codes leave the count unchanged.
- R2: The count wraps in two's complement, so one decrement from zero gives all ones.
- R3: After reset, the first sample loads the previous-state register from the synchronised inputs without counting, so steady inputs of any value give a count of zero.
- R4: Each sample after that first one writes the updated count into the queue, and the count changes only on sampling ticks.
- R5: When the queue is full and no entry is popped, a new snapshot is dropped. The queue keeps its old entries and the count keeps tracking the inputs.
- R6: If the reader sees level N, pops N+1 entries and keeps the last, that value equals the current count once the inputs have been steady.
- R7: div_i of 0 or 1 samples on every clock. A value D greater than 1 samples once every D clocks.
- R8: While rst_ni is low the queue is empty (rx_valid_o = 0, rx_level_o = 0) and the count is zero.
- R9: rx_level_o gives the number of queued entries (0 to FIFO_DEPTH). rx_valid_o is high exactly when that number is nonzero. An entry is popped on a clock edge where rx_valid_o and rx_ready_i are both high.
- R10: A change of both phase bits in one sample (codes 0011, 0110, 1001, 1100) leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Phase A, asynchronous |
| b_i | input | 1 | Phase B, asynchronous |
| div_i | input | DIV_W | Sampling divider, 0 or 1 means no division |
| rx_valid_o | output | 1 | Queue holds at least one snapshot |
| rx_ready_i | input | 1 | Reader pops the head entry |
| rx_data_o | output | CNT_W | Head snapshot of the count |
| rx_level_o | output | clog2(FIFO_DEPTH+1) | Number of queued snapshots |

## Verification
The hardest situation to reach is a full queue that holds stale snapshots while the encoder moves on, because any reader that keeps popping also keeps the queue fresh. The bench holds rx_ready_i low so the queue fills, then steps the phases. It checks that the head entry still shows the old count and that the drain-plus-one read returns the new one. All sixteen previous/new code pairs are swept with the divider off. The expected count comes from the Gray-code position difference modulo four, and the sampling period is measured from the spacing of level increments.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {ACT_HOLD, ACT_INC, ACT_DEC} act_e;

  // idx = {prev, new}, bit 1 of each pair is phase A
  function automatic act_e step_action(logic [3:0] idx);
    case (idx)
      4'b0010, 4'b0100, 4'b1011, 4'b1101: step_action = ACT_INC;
      4'b0001, 4'b0111, 4'b1000, 4'b1110: step_action = ACT_DEC;
      default:                            step_action = ACT_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         ok_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      warm_q <= '0;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      warm_q <= {warm_q[0], 1'b1};
    end
  end

  assign q_o  = s2_q;
  assign ok_o = warm_q[1];
endmodule

// File: rtl/qenc_tick.sv
module qenc_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/qenc_fifo.sv
module qenc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [W-1:0]     data_o,
  output logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             wr_en, rd_en;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign valid_o = (lvl_q != '0);
  assign rd_en   = pop_i && valid_o;
  // a snapshot is dropped only when full and nothing leaves this cycle
  assign wr_en   = push_i && ((lvl_q != FULL_LVL) || rd_en);
  assign data_o  = mem_q[rd_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_en) wr_q <= nxt(wr_q);
      if (rd_en) rd_q <= nxt(rd_q);
      case ({wr_en, rd_en})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic [CNT_W-1:0] rx_data_o,
  output logic [LVL_W-1:0] rx_level_o
);
  logic [1:0]       ph_sync, prev_q;
  logic             sync_ok, tick, primed_q, push;
  logic [3:0]       idx;
  act_e             act;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  qenc_sync #(.W(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i({a_i, b_i}),
    .q_o   (ph_sync), .ok_o(sync_ok)
  );

  qenc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  assign idx  = {prev_q, ph_sync};
  assign act  = step_action(idx);
  assign push = tick && primed_q;

  always_comb begin
    unique case (act)
      ACT_INC: cnt_d = cnt_q + CNT_W'(1);
      ACT_DEC: cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      cnt_q    <= '0;
    end else if (tick && sync_ok) begin
      prev_q   <= ph_sync;
      primed_q <= 1'b1;
      if (primed_q) cnt_q <= cnt_d;
    end
  end

  qenc_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .data_i (cnt_d),
    .pop_i  (rx_ready_i),
    .valid_o(rx_valid_o),
    .data_o (rx_data_o),
    .level_o(rx_level_o)
  );
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int CNT_W      = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             primed_q,
  input logic [3:0]       idx,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rx_valid_o,
  input logic             rx_ready_i,
  input logic [LVL_W-1:0] rx_level_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  a_r4_count_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));

  a_r1_inc_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && primed_q && idx == 4'b0010) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r1_dec_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && primed_q && idx == 4'b0001) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  a_r10_double_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && (idx == 4'b0011 || idx == 4'b0110 || idx == 4'b1001 || idx == 4'b1100))
      |=> $stable(cnt_q));

  a_r9_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level_o <= FULL_LVL);

  a_r9_valid_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o == (rx_level_o != '0));

  a_r5_full_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_o == FULL_LVL && !rx_ready_i) |=> rx_level_o == FULL_LVL);
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .primed_q(primed_q), .idx(idx),
  .cnt_q(cnt_q), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .rx_level_o(rx_level_o)
);

// File: tb/qenc_counter_tb.sv
`timescale 1ns/1ps
module qenc_counter_tb;
  localparam int CNT_W = 32, DEPTH = 4, DIV_W = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk_i = 0, rst_ni = 0, a_i = 1, b_i = 1, rx_ready_i = 0;
  logic [DIV_W-1:0] div_i = '0;
  logic             rx_valid_o;
  logic [CNT_W-1:0] rx_data_o;
  logic [LVL_W-1:0] rx_level_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [1:0]       cur_st = 2'b11;
  logic [CNT_W-1:0] exp_cnt = '0;

  always #2 clk_i = ~clk_i;

  qenc_counter #(.CNT_W(CNT_W), .FIFO_DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .div_i(div_i),
    .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
    .rx_data_o(rx_data_o), .rx_level_o(rx_level_o)
  );

  task automatic check(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Gray position: 00->0, 10->1, 11->2, 01->3
  function automatic int gpos(logic [1:0] s);
    case (s) 2'b00: return 0; 2'b10: return 1; 2'b11: return 2; default: return 3; endcase
  endfunction

  task automatic step_to(logic [1:0] s, int settle);
    int d;
    @(negedge clk_i);
    {a_i, b_i} = s;
    d = (gpos(s) - gpos(cur_st)) & 3;
    if (d == 1) exp_cnt = exp_cnt + 1;
    else if (d == 3) exp_cnt = exp_cnt - 1;
    cur_st = s;
    repeat (settle) @(negedge clk_i);
  endtask

  task automatic pop_one(output logic [CNT_W-1:0] d);
    while (!rx_valid_o) @(negedge clk_i);
    d = rx_data_o;
    rx_ready_i = 1;
    @(negedge clk_i);
    rx_ready_i = 0;
  endtask

  // drain-plus-one read
  task automatic read_count(output logic [CNT_W-1:0] last, output logic [CNT_W-1:0] first);
    int n;
    n = int'(rx_level_o) + 1;
    for (int i = 0; i < n; i++) begin
      pop_one(last);
      if (i == 0) first = last;
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] v, f;
    int t0, t1, cyc;
    logic [LVL_W-1:0] pl;

    repeat (5) @(negedge clk_i);
    check("R8 valid in reset", CNT_W'(rx_valid_o), 0);
    check("R8 level in reset", CNT_W'(rx_level_o), 0);
    rst_ni = 1;
    repeat (10) @(negedge clk_i);
    check("R9 full level while idle", CNT_W'(rx_level_o), DEPTH);
    read_count(v, f);
    check("R3 no spurious count on steady 11", v, 0);

    step_to(2'b10, 8);
    read_count(v, f);
    check("R2 wrap below zero", v, 32'hFFFF_FFFF);
    step_to(2'b11, 8);
    read_count(v, f);
    check("R1 back to zero", v, exp_cnt);

    // sweep every {prev,new} code; double steps cover R10
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 4; n++) begin
        step_to(2'(p), 8);
        read_count(v, f);
        check("R1 count at prev", v, exp_cnt);
        step_to(2'(n), 8);
        read_count(v, f);
        if (((gpos(2'(n)) - gpos(2'(p))) & 3) == 2)
          check("R10 double step ignored", v, exp_cnt);
        else
          check("R1 count after step", v, exp_cnt);
      end

    // full queue: head is stale, drain-plus-one is fresh
    repeat (10) @(negedge clk_i);
    check("R5 queue full", CNT_W'(rx_level_o), DEPTH);
    v = exp_cnt;
    step_to(cur_st + 2'b0, 0);
    begin
      logic [1:0] nx;
      nx = (cur_st == 2'b00) ? 2'b10 : (cur_st == 2'b10) ? 2'b11 :
           (cur_st == 2'b11) ? 2'b01 : 2'b00;
      step_to(nx, 10);
    end
    read_count(t0 == 0 ? v : v, f);
    check("R5 head entry stale", f, exp_cnt - 1);
    check("R6 drain plus one fresh", v, exp_cnt);

    // divider
    @(negedge clk_i);
    div_i = 16'd8;
    rx_ready_i = 1;
    repeat (40) @(negedge clk_i);
    rx_ready_i = 0;
    t0 = -1; t1 = -1; pl = rx_level_o;
    for (cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk_i);
      if (rx_level_o > pl) begin
        if (t0 < 0) t0 = cyc; else if (t1 < 0) t1 = cyc;
      end
      pl = rx_level_o;
    end
    check("R7 sample period 8", CNT_W'(t1 - t0), 8);
    check("R4 snapshot per sample", CNT_W'(rx_level_o), 4);
    step_to(2'b00 ^ cur_st ^ 2'b00, 0);
    begin
      logic [1:0] nx;
      nx = (cur_st == 2'b00) ? 2'b01 : (cur_st == 2'b01) ? 2'b11 :
           (cur_st == 2'b11) ? 2'b10 : 2'b00;
      step_to(nx, 40);
    end
    read_count(v, f);
    check("R7 count with divider", v, exp_cnt);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule